// File: doc/BRIEF.md
# Serial Control-Register Slave with Hardware Write Lock

This block is a serial peripheral slave that lets a host read and update a small configuration byte: a two-bit watchdog timeout select (one code of which turns the watchdog off), two block-protect bits and a sticky write-lock enable bit. The host drives an active-low select, a serial clock that idles low, and serial data in. The block answers on a serial data output that carries an output enable. The pad driver uses that enable to float the line whenever the slave is not selected.

All serial inputs are brought into the system clock through a synchroniser chain, and their edges are detected there. Every transaction begins with an opcode byte. Four opcodes are decoded: set the write-enable latch, clear it, read the status byte, and write the status byte. A status write commits when select is released, and only under three conditions: the latch was set, a full data byte arrived, and the register is not locked. The register is locked while the hardware protect pin is low and the stored lock-enable bit is set. No command is honoured after reset until select has been seen going from high to low.

Top module: `spi_cr_top`

## Requirements
- R1: `miso_oe_o` is low whenever select is high and before the block is armed. It is high while the armed block is selected, from a few system clocks after select falls.
- R2: After reset no command takes effect, and the output stays disabled, until `cs_n_i` has made a high-to-low transition. Bytes clocked while select has been low since reset are ignored.
- R3: Input bits are taken on rising serial-clock edges, most significant bit first. Output bits change on falling edges. The first status bit appears after the falling edge that follows the eighth rising edge of the opcode.
- R4: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. The latch reads back in status bit 1.
- R5: Opcode 0x05 returns the status byte, laid out as bit 7 lock-enable, bit 6 zero, bits 5:4 watchdog select, bits 3:2 protect bits, bit 1 write-enable latch, bit 0 zero (never busy). The byte repeats for every further byte while select stays low.
- R6: Opcode 0x01 followed by a full data byte updates bits 7, 5:4 and 3:2 of the status when select rises, provided the latch is set and the register is not locked. Data bits 6, 1 and 0 are ignored.
- R7: A status write with the latch clear changes nothing.
- R8: The latch clears when select rises after opcode 0x01 with a full data byte, whether or not the write was locked out.
- R9: While `wp_n_i` is low and the lock-enable bit is 1, the lock-enable, watchdog select and protect fields keep their values. A low pin with lock-enable 0 does not lock.
- R10: Raising select part-way through a byte discards that byte. A partial data byte after 0x01 writes nothing and leaves the latch as it was.
- R11: `wpen_o`, `wdt_sel_o` and `prot_o` mirror the stored fields. `wdt_en_o` is low exactly when the watchdog select equals 2'b11.
- R12: All fields and the latch reset to zero. Opcodes other than the four listed have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial clock, idles low |
| mosi_i | input | 1 | Serial data from host |
| wp_n_i | input | 1 | Hardware write-protect pin, active low |
| miso_o | output | 1 | Serial data to host |
| miso_oe_o | output | 1 | Output enable for the serial data pad |
| wpen_o | output | 1 | Stored lock-enable bit |
| wdt_sel_o | output | 2 | Watchdog timeout select |
| wdt_en_o | output | 1 | Watchdog enabled (select not 2'b11) |
| prot_o | output | 2 | Block-protect bits |

## Verification
The hardest state to reach from the ports is the locked one. The lock-enable bit can only be set through an unlocked write, so the stimulus first sweeps every data value through a write with the pin high, which leaves lock-enable set. Only then does it drop the pin and attempt further writes. The pre-arming state is just as awkward to reach: the bench holds select low through reset and clocks a full opcode before select ever rises. Abandoned transfers are produced by releasing select after a chosen number of bits, inside both the opcode byte and the data byte.

// File: rtl/spi_cr_pkg.sv
package spi_cr_pkg;
   localparam int BYTE_W = 8;
   localparam int IDX_W  = 2;

   localparam logic [BYTE_W-1:0] OPC_WRSR = 8'h01;
   localparam logic [BYTE_W-1:0] OPC_WRDI = 8'h04;
   localparam logic [BYTE_W-1:0] OPC_RDSR = 8'h05;
   localparam logic [BYTE_W-1:0] OPC_WREN = 8'h06;

   typedef struct packed {
      logic       wpen;
      logic [1:0] wdt_sel;
      logic [1:0] prot;
   } cfg_t;

   function automatic logic [BYTE_W-1:0] status_of(input cfg_t c, input logic wel);
      return {c.wpen, 1'b0, c.wdt_sel, c.prot, wel, 1'b0};
   endfunction

   function automatic cfg_t cfg_of(input logic [BYTE_W-1:0] b);
      cfg_t c;
      c.wpen    = b[7];
      c.wdt_sel = b[5:4];
      c.prot    = b[3:2];
      return c;
   endfunction
endpackage

// File: rtl/spi_cr_sync.sv
module spi_cr_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_cr_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("spi_cr_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_cr_edge.sv
module spi_cr_edge #(
   parameter int WIDTH = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] rise,
   output logic [WIDTH-1:0] fall
);
   logic [WIDTH-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= lvl;
   end

   for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      assign rise[g] =  lvl[g] & ~prev[g];
      assign fall[g] = ~lvl[g] &  prev[g];
   end
endmodule

// File: rtl/spi_cr_shift.sv
module spi_cr_shift import spi_cr_pkg::*; (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              start,
   input  logic              sclk_rise,
   input  logic              sclk_fall,
   input  logic              mosi,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_data,
   output logic              byte_done,
   output logic [BYTE_W-1:0] rx_byte,
   output logic [IDX_W-1:0]  byte_idx,
   output logic              miso
);
   localparam int                CNT_W    = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(BYTE_W - 1);
   localparam logic [IDX_W-1:0]  IDX_MAX  = '1;

   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] rx_sr;
   logic [BYTE_W-1:0] tx_sr;
   logic              miso_q;

   assign byte_done = active && sclk_rise && (bit_cnt == CNT_LAST);
   assign rx_byte   = {rx_sr[BYTE_W-2:0], mosi};
   assign miso      = miso_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt  <= '0;
         rx_sr    <= '0;
         tx_sr    <= '0;
         byte_idx <= '0;
         miso_q   <= 1'b0;
      end else if (start || !active) begin
         bit_cnt  <= '0;
         rx_sr    <= '0;
         tx_sr    <= '0;
         byte_idx <= '0;
         miso_q   <= 1'b0;
      end else begin
         if (sclk_rise) begin
            rx_sr   <= rx_byte;
            bit_cnt <= byte_done ? '0 : bit_cnt + 1'b1;
            if (byte_done && byte_idx != IDX_MAX) byte_idx <= byte_idx + 1'b1;
         end
         if (load) begin
            tx_sr <= load_data;
         end else if (sclk_fall) begin
            miso_q <= tx_sr[BYTE_W-1];
            tx_sr  <= tx_sr << 1;
         end
      end
   end
endmodule

// File: rtl/spi_cr_ctl.sv
module spi_cr_ctl import spi_cr_pkg::*; #(
   parameter cfg_t CFG_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s,
   input  logic              cs_fall,
   input  logic              cs_rise,
   input  logic              wp_n_s,
   input  logic              byte_done,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic [IDX_W-1:0]  byte_idx,
   output logic              armed,
   output logic              active,
   output logic              load,
   output logic [BYTE_W-1:0] load_data,
   output cfg_t              cfg,
   output logic              wel,
   output logic              wr_full,
   output logic              oe
);
   logic [BYTE_W-1:0] op_q;
   cfg_t              pend_q;
   logic              locked;
   logic              first_byte;

   assign active     = armed & ~cs_s;
   assign locked     = cfg.wpen & ~wp_n_s;
   assign first_byte = (byte_idx == '0);
   assign load_data  = status_of(cfg, wel);
   assign load       = byte_done &&
                       ((first_byte && rx_byte == OPC_RDSR) ||
                        (!first_byte && op_q == OPC_RDSR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         op_q    <= '0;
         wel     <= 1'b0;
         cfg     <= CFG_RST;
         pend_q  <= '0;
         wr_full <= 1'b0;
         oe      <= 1'b0;
      end else begin
         oe <= active;
         if (cs_fall) begin
            armed   <= 1'b1;
            op_q    <= '0;
            wr_full <= 1'b0;
         end else if (cs_rise) begin
            if (armed && op_q == OPC_WRSR && wr_full) begin
               wel <= 1'b0;
               if (wel && !locked) cfg <= pend_q;
            end
            op_q    <= '0;
            wr_full <= 1'b0;
         end else if (byte_done) begin
            if (first_byte) begin
               op_q <= rx_byte;
               if (rx_byte == OPC_WREN)      wel <= 1'b1;
               else if (rx_byte == OPC_WRDI) wel <= 1'b0;
            end else if (byte_idx == IDX_W'(1) && op_q == OPC_WRSR) begin
               pend_q  <= cfg_of(rx_byte);
               wr_full <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/spi_cr_top.sv
module spi_cr_top import spi_cr_pkg::*; #(
   parameter int         SYNC_STAGES = 2,
   parameter logic [1:0] WDT_OFF     = 2'b11,
   parameter cfg_t       CFG_RST     = '0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n_i,
   input  logic       sclk_i,
   input  logic       mosi_i,
   input  logic       wp_n_i,
   output logic       miso_o,
   output logic       miso_oe_o,
   output logic       wpen_o,
   output logic [1:0] wdt_sel_o,
   output logic       wdt_en_o,
   output logic [1:0] prot_o
);
   localparam int N_IN = 4;

   logic [N_IN-1:0]   in_s;
   logic              cs_s, sclk_s, mosi_s, wp_n_s;
   logic [1:0]        e_rise, e_fall;
   logic              cs_rise, cs_fall, sclk_rise, sclk_fall;
   logic              armed, active, load, wel, wr_full;
   logic              byte_done;
   logic [BYTE_W-1:0] rx_byte, load_data;
   logic [IDX_W-1:0]  byte_idx;
   cfg_t              cfg;

   spi_cr_sync #(.STAGES(SYNC_STAGES), .WIDTH(N_IN)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({wp_n_i, mosi_i, sclk_i, cs_n_i}),
      .q(in_s)
   );
   assign {wp_n_s, mosi_s, sclk_s, cs_s} = in_s;

   spi_cr_edge #(.WIDTH(2)) u_edge (
      .clk(clk), .rst_n(rst_n),
      .lvl({sclk_s, cs_s}),
      .rise(e_rise), .fall(e_fall)
   );
   assign {sclk_rise, cs_rise} = e_rise;
   assign {sclk_fall, cs_fall} = e_fall;

   spi_cr_shift u_shift (
      .clk(clk), .rst_n(rst_n),
      .active(active), .start(cs_fall),
      .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi(mosi_s),
      .load(load), .load_data(load_data),
      .byte_done(byte_done), .rx_byte(rx_byte), .byte_idx(byte_idx),
      .miso(miso_o)
   );

   spi_cr_ctl #(.CFG_RST(CFG_RST)) u_ctl (
      .clk(clk), .rst_n(rst_n),
      .cs_s(cs_s), .cs_fall(cs_fall), .cs_rise(cs_rise), .wp_n_s(wp_n_s),
      .byte_done(byte_done), .rx_byte(rx_byte), .byte_idx(byte_idx),
      .armed(armed), .active(active), .load(load), .load_data(load_data),
      .cfg(cfg), .wel(wel), .wr_full(wr_full), .oe(miso_oe_o)
   );

   assign wpen_o    = cfg.wpen;
   assign wdt_sel_o = cfg.wdt_sel;
   assign prot_o    = cfg.prot;
   assign wdt_en_o  = (cfg.wdt_sel != WDT_OFF);
endmodule

// File: rtl/spi_cr_chk.sv
module spi_cr_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_s,
   input logic       wp_n_s,
   input logic       cs_fall,
   input logic       cs_rise,
   input logic       sclk_fall,
   input logic       armed,
   input logic       active,
   input logic       wel,
   input logic       wr_full,
   input logic       miso_o,
   input logic       miso_oe_o,
   input logic       wpen_o,
   input logic [1:0] wdt_sel_o,
   input logic [1:0] prot_o
);
   // R1: select high in the previous cycle means the pad is released
   a_r1_float_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cs_s) |-> !miso_oe_o);

   // R2: nothing is latched or driven before the first select fall
   a_r2_no_latch_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> !wel);
   a_r2_no_drive_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> !miso_oe_o);

   // R3: serial output moves only after a falling serial clock or a transfer reset
   a_r3_miso_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (miso_o != $past(miso_o)) |-> $past(sclk_fall || cs_fall || !active));

   // R7: fields change only when the latch was set
   a_r7_write_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({wpen_o, wdt_sel_o, prot_o}) |-> $past(wel));

   // R8: latch drops after a completed status write
   a_r8_latch_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && armed && wr_full) |=> !wel);

   // R9: lock holds the fields
   a_r9_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (wpen_o && !wp_n_s) |=> $stable({wpen_o, wdt_sel_o, prot_o}));
endmodule

bind spi_cr_top spi_cr_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .wp_n_s(wp_n_s),
   .cs_fall(cs_fall), .cs_rise(cs_rise), .sclk_fall(sclk_fall),
   .armed(armed), .active(active), .wel(wel), .wr_full(wr_full),
   .miso_o(miso_o), .miso_oe_o(miso_oe_o), .wpen_o(wpen_o),
   .wdt_sel_o(wdt_sel_o), .prot_o(prot_o)
);

// File: tb/sim_spi_cr_top.sv
`timescale 1ns/1ps
module sim_spi_cr_top;
   localparam int HALF = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b0, sclk = 1'b0, mosi = 1'b0, wp_n = 1'b1;
   logic       miso, miso_oe, wpen, wdt_en;
   logic [1:0] wdt_sel, prot;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   spi_cr_top u0 (
      .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .mosi_i(mosi),
      .wp_n_i(wp_n), .miso_o(miso), .miso_oe_o(miso_oe), .wpen_o(wpen),
      .wdt_sel_o(wdt_sel), .wdt_en_o(wdt_en), .prot_o(prot)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic xfer_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
      rx = '0;
      for (int i = 7; i > 7 - nb; i--) begin
         mosi = tx[i];
         tick(HALF);
         rx[i] = miso;
         sclk = 1'b1;
         tick(HALF);
         sclk = 1'b0;
      end
   endtask

   task automatic sel();
      cs_n = 1'b0;
      tick(6);
   endtask

   task automatic desel();
      tick(HALF);
      cs_n = 1'b1;
      tick(6);
   endtask

   task automatic cmd(input logic [7:0] op);
      logic [7:0] r;
      sel();
      xfer_bits(op, 8, r);
      desel();
   endtask

   task automatic wrsr(input logic [7:0] d);
      logic [7:0] r;
      sel();
      xfer_bits(8'h01, 8, r);
      xfer_bits(d, 8, r);
      desel();
   endtask

   task automatic rdsr(output logic [7:0] s);
      logic [7:0] r;
      sel();
      xfer_bits(8'h05, 8, r);
      xfer_bits(8'h00, 8, s);
      desel();
   endtask

   initial begin
      logic [7:0] s, a, b, r;
      // select held low through reset: the block must stay unarmed
      tick(5);
      rst_n = 1'b1;
      tick(6);
      chk("R1 R2 oe low before arming", int'(miso_oe), 0);
      xfer_bits(8'h06, 8, r);
      chk("R2 oe low during unarmed bytes", int'(miso_oe), 0);
      tick(HALF);
      cs_n = 1'b1;
      tick(6);
      chk("R1 oe low deselected", int'(miso_oe), 0);
      rdsr(s);
      chk("R2 R12 unarmed opcode ignored, reset status", int'(s), 8'h00);
      chk("R11 R12 reset outputs", int'({wpen, wdt_sel, prot, wdt_en}), 6'b000001);

      sel();
      chk("R1 oe high while selected", int'(miso_oe), 1);
      xfer_bits(8'h05, 8, r);
      xfer_bits(8'h00, 8, r);
      desel();
      chk("R1 oe low after release", int'(miso_oe), 0);

      cmd(8'h06);
      rdsr(s);
      chk("R4 write-enable sets latch", int'(s), 8'h02);
      cmd(8'h04);
      rdsr(s);
      chk("R4 write-disable clears latch", int'(s), 8'h00);

      wrsr(8'hFC);
      rdsr(s);
      chk("R7 write without latch ignored", int'(s), 8'h00);

      // full sweep of data values, pin high so never locked
      for (int d = 0; d < 256; d++) begin
         cmd(8'h06);
         wrsr(8'(d));
         rdsr(s);
         chk("R3 R6 R8 status after write", int'(s), d & 8'hBC);
         chk("R11 field outputs", int'({wpen, wdt_sel, prot, wdt_en}),
             int'({d[7], d[5:4], d[3:2], (d[5:4] != 2'b11)}));
      end

      // lock-enable now 1: drop the pin
      wp_n = 1'b0;
      tick(4);
      cmd(8'h06);
      wrsr(8'h00);
      rdsr(s);
      chk("R8 R9 locked write ignored, latch cleared", int'(s), 8'hBC);
      chk("R9 R11 outputs held while locked", int'({wpen, wdt_sel, prot}), 5'b11111);

      wp_n = 1'b1;
      tick(4);
      cmd(8'h06);
      wrsr(8'h30);
      rdsr(s);
      chk("R9 pin high unlocks", int'(s), 8'h30);
      chk("R11 watchdog off code", int'(wdt_en), 0);
      wp_n = 1'b0;
      tick(4);
      cmd(8'h06);
      wrsr(8'h0C);
      rdsr(s);
      chk("R9 pin low without lock-enable does not lock", int'(s), 8'h0C);
      wp_n = 1'b1;

      // abandoned transfers
      cmd(8'h06);
      sel();
      xfer_bits(8'h01, 8, r);
      xfer_bits(8'hF0, 5, r);
      desel();
      rdsr(s);
      chk("R10 partial data byte writes nothing, latch kept", int'(s), 8'h0E);
      sel();
      xfer_bits(8'h04, 4, r);
      desel();
      rdsr(s);
      chk("R10 partial opcode discarded", int'(s), 8'h0E);

      // unknown opcodes
      cmd(8'hA5);
      cmd(8'h07);
      sel();
      xfer_bits(8'h00, 8, r);
      xfer_bits(8'hFF, 8, r);
      desel();
      rdsr(s);
      chk("R12 unknown opcodes no effect", int'(s), 8'h0E);

      // repeated status bytes in one transaction
      cmd(8'h04);
      sel();
      xfer_bits(8'h05, 8, r);
      chk("R3 output zero during opcode", int'(r), 8'h00);
      xfer_bits(8'h00, 8, a);
      xfer_bits(8'h00, 8, b);
      desel();
      chk("R5 first status byte", int'(a), 8'h0C);
      chk("R5 repeated status byte", int'(b), 8'h0C);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog (all requirements): actual hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule